// File: doc/BRIEF.md
# DMA Chained Descriptor Fetch Sequencer

This block serves one DMA channel that works through a chain of transfer descriptors held in memory. When the channel starts, or finishes a descriptor and moves to the next one, the block receives a start strobe and the address of a descriptor. It then reads the four words of that descriptor on a simple read port, one word per cycle. From those words it produces the values the channel registers need:

- the increment and select flags;
- the total transfer size;
- the source and destination addresses;
- the new descriptor pointer;
- the address of the descriptor just fetched.

A one-cycle done strobe marks when these values are complete. A chain flag tells the channel whether another descriptor follows, or whether the list ends when the current transfer completes.

The memory read port is combinational. Read data must be valid in the same cycle as the read enable and the address. The descriptor's word order is fixed: control word at offset 0, source address at offset 4, destination address at offset 8, next-descriptor pointer at offset 12. The caller supplies the current size register. The block returns it with only the total-size field replaced, so the chunk-size bits pass through unchanged.

Top module: `desc_fetch_seq`

## Requirements
- R1: After reset, busy_o, done_o and rd_en_o are low, and every captured output is zero: addresses, flags, and size bits 11:0. chain_o is therefore high.
- R2: A start_i sampled while idle causes four reads in the four following cycles, at desc_ptr_i+0, +4, +8 and +12 in that order.
- R3: done_o is high for exactly one cycle, the cycle after the last read. busy_o is high from the cycle after the accepted start through the done cycle.
- R4: The control-word bits map to the flags as follows: bit 19 drives inc_src_o, bit 18 drives inc_dst_o, bit 17 drives src_sel_o and bit 16 drives dst_sel_o.
- R5: size_reg_o[11:0] equals control-word bits 11:0. size_reg_o[31:12] equals size_reg_i[31:12].
- R6: chain_o is the inverse of control-word bit 20, the end-of-list bit.
- R7: src_addr_o and dst_addr_o equal the words read at offsets 4 and 8.
- R8: cur_desc_o equals the desc_ptr_i accepted with the start. next_desc_o equals the word read at offset 12.
- R9: A start_i that arrives while busy_o is high is ignored. The read sequence and addresses in progress are unchanged, and no new fetch begins.
- R10: While idle with no start, all outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a descriptor fetch (taken only when idle) |
| desc_ptr_i | input | AW | Address of the descriptor to fetch |
| size_reg_i | input | DW | Current channel size register |
| rd_en_o | output | 1 | Memory read enable |
| rd_addr_o | output | AW | Memory read address |
| rd_data_i | input | DW | Memory read data, same cycle as rd_en_o |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle strobe: all outputs updated |
| chain_o | output | 1 | Another descriptor follows |
| inc_src_o | output | 1 | Source increment flag |
| inc_dst_o | output | 1 | Destination increment flag |
| src_sel_o | output | 1 | Source select flag |
| dst_sel_o | output | 1 | Destination select flag |
| size_reg_o | output | DW | Size register with the total-size field replaced |
| src_addr_o | output | DW | Fetched source address |
| dst_addr_o | output | DW | Fetched destination address |
| next_desc_o | output | DW | New descriptor pointer |
| cur_desc_o | output | AW | Address of the descriptor just fetched |

## Verification
The assertions check on every cycle:
- reads occur only while busy, and their addresses step by one word;
- an accepted start leads straight to a read at the accepted pointer, and a start that arrives while busy is never accepted;
- done is a single pulse that follows the final read;
- on the done cycle, the chain flag, the size field and the next pointer agree with the data returned on the read port;
- outputs stay stable while idle.

Only the bench scenarios can show the following:
- the complete field mapping for descriptors with different flag patterns;
- the upper size bits passing through unchanged;
- starts that land in the middle of a fetch or on its done cycle being dropped;
- a fetch launched on the first idle cycle after done.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

  // sequencer states; the four read states follow the descriptor word order
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CTRL = 3'd1,
    ST_SRC  = 3'd2,
    ST_DST  = 3'd3,
    ST_NEXT = 3'd4,
    ST_FIN  = 3'd5
  } dfs_state_e;

  localparam int SLOTS  = 4;
  localparam int SLOT_W = $clog2(SLOTS);

  // word slot indices within a descriptor
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_SRC  = 1;
  localparam int SLOT_DST  = 2;
  localparam int SLOT_NEXT = 3;

  // control word bit positions
  localparam int BIT_EOL     = 20;
  localparam int BIT_INC_SRC = 19;
  localparam int BIT_INC_DST = 18;
  localparam int BIT_SEL_SRC = 17;
  localparam int BIT_SEL_DST = 16;

  function automatic logic is_read_state(dfs_state_e s);
    return (s == ST_CTRL) || (s == ST_SRC) || (s == ST_DST) || (s == ST_NEXT);
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(dfs_state_e s);
    logic [SLOT_W-1:0] r;
    case (s)
      ST_SRC:  r = SLOT_W'(SLOT_SRC);
      ST_DST:  r = SLOT_W'(SLOT_DST);
      ST_NEXT: r = SLOT_W'(SLOT_NEXT);
      default: r = SLOT_W'(SLOT_CTRL);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dfs_ctrl.sv
module dfs_ctrl
  import dfs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW-1:0]     desc_ptr_i,
  output logic              launch_o,
  output logic              busy_o,
  output logic              rd_en_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              done_o,
  output logic [AW-1:0]     cur_desc_o
);

  dfs_state_e    state_q, state_d;
  logic [AW-1:0] base_q;

  // byte address of one descriptor word
  function automatic logic [AW-1:0] slot_addr(logic [AW-1:0] base, logic [SLOT_W-1:0] slot);
    return base + (AW'(slot) * AW'(WORD_BYTES));
  endfunction

  assign launch_o = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (launch_o) state_d = ST_CTRL;
      ST_CTRL: state_d = ST_SRC;
      ST_SRC:  state_d = ST_DST;
      ST_DST:  state_d = ST_NEXT;
      ST_NEXT: state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      if (launch_o) base_q <= desc_ptr_i;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign rd_en_o    = is_read_state(state_q);
  assign slot_o     = slot_of(state_q);
  assign rd_addr_o  = rd_en_o ? slot_addr(base_q, slot_o) : '0;
  assign done_o     = (state_q == ST_FIN);
  assign cur_desc_o = base_q;

endmodule

// File: rtl/dfs_capture.sv
module dfs_capture
  import dfs_pkg::*;
#(
  parameter int DW    = 32,
  parameter int TSZ_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DW-1:0]     rd_data_i,
  input  logic [DW-1:0]     size_reg_i,
  output logic              chain_o,
  output logic              inc_src_o,
  output logic              inc_dst_o,
  output logic              src_sel_o,
  output logic              dst_sel_o,
  output logic [DW-1:0]     size_reg_o,
  output logic [DW-1:0]     src_addr_o,
  output logic [DW-1:0]     dst_addr_o,
  output logic [DW-1:0]     next_desc_o
);

  logic [DW-1:0] words_q [SLOTS];

  // replace only the total-size field, keep every other bit
  function automatic logic [DW-1:0] merge_size(logic [DW-1:0] cur, logic [DW-1:0] ctrl);
    logic [DW-1:0] m;
    m = {{(DW-TSZ_W){1'b0}}, {TSZ_W{1'b1}}};
    return (cur & ~m) | (ctrl & m);
  endfunction

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     words_q[g] <= '0;
      else if (rd_en_i && (slot_i == SLOT_W'(g)))     words_q[g] <= rd_data_i;
    end
  end

  assign chain_o     = ~words_q[SLOT_CTRL][BIT_EOL];
  assign inc_src_o   = words_q[SLOT_CTRL][BIT_INC_SRC];
  assign inc_dst_o   = words_q[SLOT_CTRL][BIT_INC_DST];
  assign src_sel_o   = words_q[SLOT_CTRL][BIT_SEL_SRC];
  assign dst_sel_o   = words_q[SLOT_CTRL][BIT_SEL_DST];
  assign size_reg_o  = merge_size(size_reg_i, words_q[SLOT_CTRL]);
  assign src_addr_o  = words_q[SLOT_SRC];
  assign dst_addr_o  = words_q[SLOT_DST];
  assign next_desc_o = words_q[SLOT_NEXT];

endmodule

// File: rtl/desc_fetch_seq.sv
module desc_fetch_seq
  import dfs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int TSZ_W      = 12,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] desc_ptr_i,
  input  logic [DW-1:0] size_reg_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          chain_o,
  output logic          inc_src_o,
  output logic          inc_dst_o,
  output logic          src_sel_o,
  output logic          dst_sel_o,
  output logic [DW-1:0] size_reg_o,
  output logic [DW-1:0] src_addr_o,
  output logic [DW-1:0] dst_addr_o,
  output logic [DW-1:0] next_desc_o,
  output logic [AW-1:0] cur_desc_o
);

  // named internal events, visible to the bound checker
  logic              launch;
  logic [SLOT_W-1:0] fetch_slot;

  dfs_ctrl #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .desc_ptr_i (desc_ptr_i),
    .launch_o   (launch),
    .busy_o     (busy_o),
    .rd_en_o    (rd_en_o),
    .rd_addr_o  (rd_addr_o),
    .slot_o     (fetch_slot),
    .done_o     (done_o),
    .cur_desc_o (cur_desc_o)
  );

  dfs_capture #(.DW(DW), .TSZ_W(TSZ_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en_i     (rd_en_o),
    .slot_i      (fetch_slot),
    .rd_data_i   (rd_data_i),
    .size_reg_i  (size_reg_i),
    .chain_o     (chain_o),
    .inc_src_o   (inc_src_o),
    .inc_dst_o   (inc_dst_o),
    .src_sel_o   (src_sel_o),
    .dst_sel_o   (dst_sel_o),
    .size_reg_o  (size_reg_o),
    .src_addr_o  (src_addr_o),
    .dst_addr_o  (dst_addr_o),
    .next_desc_o (next_desc_o)
  );

endmodule

// File: rtl/dfs_chk.sv
module dfs_chk #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int TSZ_W      = 12,
  parameter int WORD_BYTES = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [AW-1:0] desc_ptr_i,
  input logic          launch,
  input logic          rd_en_o,
  input logic [AW-1:0] rd_addr_o,
  input logic [DW-1:0] rd_data_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          chain_o,
  input logic [DW-1:0] size_reg_o,
  input logic [DW-1:0] src_addr_o,
  input logic [DW-1:0] next_desc_o,
  input logic [AW-1:0] cur_desc_o
);

  p_read_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> busy_o);

  p_launch_reads_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (rd_en_o && rd_addr_o == $past(desc_ptr_i)));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == $past(rd_addr_o) + AW'(WORD_BYTES)));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(rd_en_o) && !rd_en_o && busy_o));

  p_size_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (size_reg_o[TSZ_W-1:0] == $past(rd_data_i[TSZ_W-1:0], 4)));

  p_chain_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (chain_o != $past(rd_data_i[20], 4)));

  p_next_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (next_desc_o == $past(rd_data_i)));

  p_busy_start_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |-> !launch);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(src_addr_o) && $stable(next_desc_o) && $stable(cur_desc_o)));

endmodule

bind desc_fetch_seq dfs_chk #(.AW(AW), .DW(DW), .TSZ_W(TSZ_W), .WORD_BYTES(WORD_BYTES)) u_chk (.*);

// File: tb/sim_desc_fetch_seq.sv
`timescale 1ns/1ps
module sim_desc_fetch_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] desc_ptr_i = '0;
  logic [31:0] size_reg_i = '0;
  logic        rd_en_o;
  logic [31:0] rd_addr_o;
  logic [31:0] rd_data_i;
  logic        busy_o, done_o, chain_o;
  logic        inc_src_o, inc_dst_o, src_sel_o, dst_sel_o;
  logic [31:0] size_reg_o, src_addr_o, dst_addr_o, next_desc_o, cur_desc_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [31:0] mem [64];

  always #2 clk = ~clk;

  // combinational memory: data valid with the address
  assign rd_data_i = mem[rd_addr_o[7:2]];

  desc_fetch_seq u0 (.*);

  // behavioural reference: phase 0 idle, 1..4 reads, 5 done
  int          ph = 0;
  logic [31:0] base = '0;
  logic [31:0] ew [4] = '{default: '0};

  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else if (ph == 0) begin
      if (start_i) begin
        ph = 1;
        base = desc_ptr_i;
        for (int k = 0; k < 4; k++) ew[k] = mem[(desc_ptr_i >> 2) + k];
      end
    end else if (ph == 5) ph = 0;
    else ph = ph + 1;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 busy", 32'(busy_o), 32'(ph != 0));
      chk("R3 done", 32'(done_o), 32'(ph == 5));
      chk("R2 rd_en", 32'(rd_en_o), 32'(ph >= 1 && ph <= 4));
      if (ph >= 1 && ph <= 4)
        chk("R2/R9 rd_addr", rd_addr_o, base + 32'((ph - 1) * 4));
      if (ph == 0 || ph == 5) begin
        chk("R4 inc_src", 32'(inc_src_o), 32'(ew[0][19]));
        chk("R4 inc_dst", 32'(inc_dst_o), 32'(ew[0][18]));
        chk("R4 src_sel", 32'(src_sel_o), 32'(ew[0][17]));
        chk("R4 dst_sel", 32'(dst_sel_o), 32'(ew[0][16]));
        chk("R5 size_reg", size_reg_o, {size_reg_i[31:12], ew[0][11:0]});
        chk("R6 chain", 32'(chain_o), 32'(!ew[0][20]));
        chk("R7 src_addr", src_addr_o, ew[1]);
        chk("R7 dst_addr", dst_addr_o, ew[2]);
        chk("R8 next_desc", next_desc_o, ew[3]);
        chk("R8/R1/R10 cur_desc", cur_desc_o, base);
      end
    end
  end

  task automatic pulse(logic [31:0] p);
    start_i = 1'b1;
    desc_ptr_i = p;
    @(posedge clk) #1;
    start_i = 1'b0;
    desc_ptr_i = 32'hDEAD_0000;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk) #1;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h3C00_0000 ^ (32'(i) * 32'h0101_0101);
    // descriptor at 0x10: chains (bit20=0), inc_src=1, src_sel=1, size 0x123
    mem[4]  = 32'h5A0A_C123; mem[5] = 32'h1000_0040; mem[6] = 32'h2000_0080; mem[7] = 32'h0000_0040;
    // descriptor at 0x40: end of list, inc_dst=1, dst_sel=1, size 0xFFF
    mem[16] = 32'h0015_0FFF; mem[17] = 32'hAAAA_5554; mem[18] = 32'h5555_AAA8; mem[19] = 32'h0000_00F0;
    // descriptor at 0xF0: end of list, all flags, size 0
    mem[60] = 32'hFF1F_F000; mem[61] = 32'h0000_0004; mem[62] = 32'hFFFF_FFFC; mem[63] = 32'h8000_0000;

    idle(3);
    @(posedge clk) #1 rst_n = 1'b1;   // R1 checked by the idle compares
    idle(3);

    size_reg_i = 32'h0ABC_D000;
    pulse(32'h10);                     // R2..R8 chained descriptor
    idle(8);

    size_reg_i = 32'hFFFF_F555;
    pulse(32'h40);                     // R9: starts below land while busy
    pulse(32'h80);
    idle(2);
    pulse(32'h90);
    pulse(32'h90);                     // lands on the done cycle
    idle(6);                           // R10 hold while idle

    pulse(32'hF0);                     // top words of memory
    idle(5);
    pulse(32'h10);                     // first idle cycle after done
    idle(8);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule